// File: doc/BRIEF.md
# Indirect Nonvolatile Byte Store Controller

This block sits between a 4-bit processor bus and a 64-byte nonvolatile array. The array has two pages of 32 bytes each. Software reaches the array only through a small window of nibble-wide registers. It loads the low four address bits into an address register and the byte to store into two data registers, one for each nibble. It then writes a control register that carries address bit 4, the page bit and the direction bit. That control write alone launches the operation. Software never handles the page split itself: the six address bits `{page, bit4, low nibble}` give one flat byte index.

A read drives an array read strobe. Its width is 1.5 clock cycles in the normal clock configuration and 3.5 cycles in the fast one, and the byte is latched into the two data registers when the strobe ends. A write is self-timed and long. A cycle counter, sized from the clock frequency and the nominal write time, holds a busy flag for the whole erase-then-program sequence. At the end the block sets an interrupt flag, which is masked after reset. Entering sleep or applying reset cancels a write in flight.

Top module: `nvm_indirect_ctl`

Register map on `bus_sel_i`:
- 0: address low nibble.
- 1: data low nibble.
- 2: data high nibble.
- 3: control. Bit 0 is address bit 4, bit 1 is the page, bit 2 is the direction (1 = write), and bit 3 is busy (read only).
- 4: interrupt. Bit 0 is the flag (write 1 to clear) and bit 1 is the mask (1 = masked). A write to this register loads the mask from bit 1.
- 5 to 7: read as zero.

## Requirements
- R1: After reset, registers 0 to 3 read 0, register 4 reads 4'b0010 (flag clear, mask set), and `irq_o` and `rd_strobe_o` are 0.
- R2: The byte index is {control bit 1 (page), control bit 0, address register}, with the page as index bit 5, so that all 64 bytes are distinct locations.
- R3: A control write with bit 2 = 0 loads the addressed byte into the data registers: the low nibble into register 1 and the high nibble into register 2. The new data is readable one cycle after the control-write edge in normal mode and three cycles after it in fast mode. Before that, the old value reads back.
- R4: `rd_strobe_o` rises at the control-write edge and falls on a falling clock edge. It stays high for 1.5 cycles when `fast_rd_i` = 0 and for 3.5 cycles when `fast_rd_i` = 1.
- R5: A control write with bit 2 = 1 sets busy (register 3 bit 3) for exactly WR_CYCLES = CLK_HZ·WRITE_US/10^6 cycles. After that, the byte {register 2, register 1} is stored at the index.
- R6: While busy is 1, writes to registers 0 to 3 are ignored, so the register readback and the stored byte are unchanged.
- R7: Completion of a write sets the interrupt flag. `irq_o` is 1 only when the flag is set and the mask is clear.
- R8: Writing register 4 with bit 0 = 1 clears the flag. If that write and a write completion occur in the same cycle, the flag stays set.
- R9: Sleep asserted while busy clears busy at the next edge. The flag is not set, and the target byte reads back 8'hFF.
- R10: A reset during a write, once the write is at least one cycle old, clears busy and leaves the target byte at 8'hFF. All other bytes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep entry; cancels a write in progress |
| fast_rd_i | input | 1 | 1 selects the 3.5-cycle read strobe |
| bus_we_i | input | 1 | Register write enable |
| bus_sel_i | input | 3 | Register select |
| bus_wdata_i | input | 4 | Register write data |
| bus_rdata_o | output | 4 | Register read data (combinational) |
| rd_strobe_o | output | 1 | Array read strobe |
| irq_o | output | 1 | Write-complete interrupt request |

## Verification
Directed cases exercise the read path in both strobe modes on the same byte. Sampling on both clock phases shows the half-cycle tail and the exact cycle in which the data registers switch from old to new data. Four addresses that differ only in index bits 4 and 5 are written with distinct values and read back, which exposes any error in how the page bit and address bit 4 are merged. Writes are tried with exact busy-length timing, with register writes during busy, with a clear that collides with completion, and with sleep and reset aborts. A seeded random phase then writes random bytes in random nibble order, reads them back in random strobe modes, and compares each result with a bench-side image of the array.

// File: rtl/nvm_ctl_pkg.sv
package nvm_ctl_pkg;
   localparam int NIB_W      = 4;
   localparam int BYTE_W     = 2 * NIB_W;
   localparam int PAGE_BYTES = 32;
   localparam int NUM_PAGES  = 2;
   localparam int IDX_W      = $clog2(PAGE_BYTES * NUM_PAGES);

   typedef enum logic [2:0] {
      SEL_ADDR = 3'd0,
      SEL_DLO  = 3'd1,
      SEL_DHI  = 3'd2,
      SEL_CTL  = 3'd3,
      SEL_IRQ  = 3'd4
   } reg_sel_e;

   // control register bit positions
   localparam int CTL_A4    = 0;
   localparam int CTL_PAGE  = 1;
   localparam int CTL_WRITE = 2;
   localparam int CTL_BUSY  = 3;

   // interrupt register bit positions
   localparam int IRQ_FLAG = 0;
   localparam int IRQ_MASK = 1;

   localparam logic [BYTE_W-1:0] ERASED_BYTE = '1;
endpackage

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
   parameter int PAGE_BYTES = 32,
   parameter int NUM_PAGES  = 2,
   parameter int BYTE_W     = 8,
   localparam int OFS_W = $clog2(PAGE_BYTES),
   localparam int PG_W  = $clog2(NUM_PAGES),
   localparam int IDX_W = OFS_W + PG_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [BYTE_W-1:0] rdata
);
   initial begin
      assert (NUM_PAGES >= 2 && (1 << PG_W) == NUM_PAGES)
         else $error("NUM_PAGES must be a power of two >= 2");
      assert ((1 << OFS_W) == PAGE_BYTES)
         else $error("PAGE_BYTES must be a power of two");
   end

   logic [BYTE_W-1:0] page_rd [NUM_PAGES];

   for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
      logic [BYTE_W-1:0] cells [PAGE_BYTES];
      always_ff @(posedge clk) begin
         if (we && waddr[IDX_W-1:OFS_W] == PG_W'(p))
            cells[waddr[OFS_W-1:0]] <= wdata;
      end
      assign page_rd[p] = cells[raddr[OFS_W-1:0]];
   end

   assign rdata = page_rd[raddr[IDX_W-1:OFS_W]];
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
   parameter int unsigned WR_CYCLES = 786,
   localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sleep,
   output logic busy,
   output logic erase,
   output logic done,
   output logic abort
);
   initial begin
      assert (WR_CYCLES >= 2) else $error("WR_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign abort = busy && sleep;
   assign erase = busy && !sleep && cnt_q == CNT_W'(WR_CYCLES);
   assign done  = busy && !sleep && cnt_q == CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= CNT_W'(WR_CYCLES);
      end else if (busy) begin
         if (cnt_q == CNT_W'(1)) busy <= 1'b0;
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end
endmodule

// File: rtl/nvm_rd_strobe.sv
module nvm_rd_strobe #(
   parameter int  NORM_RD_CYC     = 1,
   parameter int  FAST_RD_CYC     = 3,
   parameter bit  HALF_CYCLE_TAIL = 1'b1,
   localparam int LEFT_W = $clog2(FAST_RD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fast,
   output logic strobe,
   output logic latch
);
   initial begin
      assert (NORM_RD_CYC >= 1 && FAST_RD_CYC >= NORM_RD_CYC)
         else $error("read strobe cycle counts out of range");
   end

   logic [LEFT_W-1:0] left_q;
   logic              active;

   assign active = left_q != '0;
   assign latch  = left_q == LEFT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      left_q <= '0;
      else if (start)  left_q <= fast ? LEFT_W'(FAST_RD_CYC) : LEFT_W'(NORM_RD_CYC);
      else if (active) left_q <= left_q - LEFT_W'(1);
   end

   if (HALF_CYCLE_TAIL) begin : g_tail
      logic tail_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) tail_q <= 1'b0;
         else        tail_q <= active;
      end
      assign strobe = active || tail_q;
   end else begin : g_whole
      assign strobe = active;
   end
endmodule

// File: rtl/nvm_indirect_ctl.sv
module nvm_indirect_ctl
   import nvm_ctl_pkg::*;
#(
   parameter int unsigned CLK_HZ          = 32768,
   parameter int unsigned WRITE_US        = 24000,
   parameter int          NORM_RD_CYC     = 1,
   parameter int          FAST_RD_CYC     = 3,
   parameter bit          HALF_CYCLE_TAIL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_i,
   input  logic       fast_rd_i,
   input  logic       bus_we_i,
   input  logic [2:0] bus_sel_i,
   input  logic [3:0] bus_wdata_i,
   output logic [3:0] bus_rdata_o,
   output logic       rd_strobe_o,
   output logic       irq_o
);
   localparam longint unsigned WR_PROD   = longint'(CLK_HZ) * longint'(WRITE_US);
   localparam int unsigned     WR_CYCLES = int'(WR_PROD / 64'd1000000);

   initial begin
      assert (WR_CYCLES >= 2) else $error("write time too short for clock");
   end

   logic [NIB_W-1:0]  addr_lo_q, dlo_q, dhi_q;
   logic [2:0]        ctl_q;           // {write, page, a4}
   logic              irq_flag_q, irq_mask_q;
   logic              wr_busy, wr_erase, wr_done, wr_abort;
   logic              rd_latch;
   logic              wr_ok, ctl_go, rd_go, wr_go, irq_clr;
   logic [IDX_W-1:0]  byte_idx;
   logic [BYTE_W-1:0] arr_rdata, arr_wdata;
   logic              arr_we;

   assign wr_ok   = bus_we_i && !wr_busy;
   assign ctl_go  = wr_ok && bus_sel_i == SEL_CTL;
   assign rd_go   = ctl_go && !bus_wdata_i[CTL_WRITE];
   assign wr_go   = ctl_go &&  bus_wdata_i[CTL_WRITE];
   assign irq_clr = bus_we_i && bus_sel_i == SEL_IRQ && bus_wdata_i[IRQ_FLAG];

   assign byte_idx = {ctl_q[CTL_PAGE], ctl_q[CTL_A4], addr_lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lo_q  <= '0;
         dlo_q      <= '0;
         dhi_q      <= '0;
         ctl_q      <= '0;
         irq_flag_q <= 1'b0;
         irq_mask_q <= 1'b1;
      end else begin
         if (wr_ok && bus_sel_i == SEL_ADDR) addr_lo_q <= bus_wdata_i;
         if (rd_latch) begin
            dlo_q <= arr_rdata[NIB_W-1:0];
            dhi_q <= arr_rdata[BYTE_W-1:NIB_W];
         end else begin
            if (wr_ok && bus_sel_i == SEL_DLO) dlo_q <= bus_wdata_i;
            if (wr_ok && bus_sel_i == SEL_DHI) dhi_q <= bus_wdata_i;
         end
         if (ctl_go) ctl_q <= bus_wdata_i[2:0];
         if (wr_done)      irq_flag_q <= 1'b1;
         else if (irq_clr) irq_flag_q <= 1'b0;
         if (bus_we_i && bus_sel_i == SEL_IRQ) irq_mask_q <= bus_wdata_i[IRQ_MASK];
      end
   end

   assign irq_o = irq_flag_q && !irq_mask_q;

   always_comb begin
      case (bus_sel_i)
         SEL_ADDR: bus_rdata_o = addr_lo_q;
         SEL_DLO:  bus_rdata_o = dlo_q;
         SEL_DHI:  bus_rdata_o = dhi_q;
         SEL_CTL:  bus_rdata_o = {wr_busy, ctl_q};
         SEL_IRQ:  bus_rdata_o = {2'b00, irq_mask_q, irq_flag_q};
         default:  bus_rdata_o = '0;
      endcase
   end

   nvm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_go),
      .sleep (sleep_i),
      .busy  (wr_busy),
      .erase (wr_erase),
      .done  (wr_done),
      .abort (wr_abort)
   );

   nvm_rd_strobe #(
      .NORM_RD_CYC     (NORM_RD_CYC),
      .FAST_RD_CYC     (FAST_RD_CYC),
      .HALF_CYCLE_TAIL (HALF_CYCLE_TAIL)
   ) u_rstb (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (rd_go),
      .fast   (fast_rd_i),
      .strobe (rd_strobe_o),
      .latch  (rd_latch)
   );

   assign arr_we    = wr_erase || wr_done || wr_abort;
   assign arr_wdata = wr_done ? {dhi_q, dlo_q} : ERASED_BYTE;

   nvm_cell_array #(
      .PAGE_BYTES (PAGE_BYTES),
      .NUM_PAGES  (NUM_PAGES),
      .BYTE_W     (BYTE_W)
   ) u_array (
      .clk   (clk),
      .we    (arr_we),
      .waddr (byte_idx),
      .wdata (arr_wdata),
      .raddr (byte_idx),
      .rdata (arr_rdata)
   );
endmodule

// File: rtl/nvm_indirect_ctl_chk.sv
module nvm_indirect_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_i,
   input logic       bus_we_i,
   input logic [2:0] bus_sel_i,
   input logic [3:0] bus_wdata_i,
   input logic       busy,
   input logic       irq_flag,
   input logic [3:0] addr_lo,
   input logic [2:0] ctl_bits
);
   // R6
   addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bus_we_i && bus_sel_i == 3'd0 |=> $stable(addr_lo));

   // R6
   ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bus_we_i && bus_sel_i == 3'd3 |=> $stable(ctl_bits));

   // R9
   sleep_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && sleep_i |=> !busy && !$rose(irq_flag));

   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(busy));

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !(bus_we_i && bus_sel_i == 3'd4 && bus_wdata_i[0]) |=> irq_flag);

   // R5
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && !$past(sleep_i) |-> irq_flag);
endmodule

bind nvm_indirect_ctl nvm_indirect_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_i     (sleep_i),
   .bus_we_i    (bus_we_i),
   .bus_sel_i   (bus_sel_i),
   .bus_wdata_i (bus_wdata_i),
   .busy        (wr_busy),
   .irq_flag    (irq_flag_q),
   .addr_lo     (addr_lo_q),
   .ctl_bits    (ctl_q)
);

// File: tb/nvm_indirect_ctl_tb.sv
`timescale 1ns/100ps
module nvm_indirect_ctl_tb;
   localparam int unsigned CLK_HZ   = 1_000_000;
   localparam int unsigned WRITE_US = 40;
   localparam int W = (CLK_HZ * WRITE_US) / 1_000_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_i = 1'b0;
   logic       fast_rd_i = 1'b0;
   logic       bus_we_i = 1'b0;
   logic [2:0] bus_sel_i = 3'd0;
   logic [3:0] bus_wdata_i = 4'd0;
   logic [3:0] bus_rdata_o;
   logic       rd_strobe_o, irq_o;

   int checks = 0;
   int failures = 0;
   bit done_flag = 0;
   logic [7:0] img [64];
   bit         img_ok [64];

   always #2 clk = ~clk;

   nvm_indirect_ctl #(.CLK_HZ(CLK_HZ), .WRITE_US(WRITE_US)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .fast_rd_i(fast_rd_i),
      .bus_we_i(bus_we_i), .bus_sel_i(bus_sel_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .rd_strobe_o(rd_strobe_o), .irq_o(irq_o));

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_wr(logic [2:0] s, logic [3:0] d);
      @(negedge clk);
      bus_we_i = 1'b1; bus_sel_i = s; bus_wdata_i = d;
      @(negedge clk);
      bus_we_i = 1'b0;
   endtask

   task automatic peek(logic [2:0] s, output logic [3:0] v);
      bus_sel_i = s;
      #0.2;
      v = bus_rdata_o;
   endtask

   function automatic logic [3:0] ctl_word(logic wr, logic [5:0] a);
      return {1'b0, wr, a[5], a[4]};
   endfunction

   task automatic start_write(logic [5:0] a, logic [7:0] d, bit shuffle);
      int order = shuffle ? int'($urandom_range(0, 2)) : 0;
      for (int k = 0; k < 3; k++) begin
         case ((k + order) % 3)
            0: bus_wr(3'd0, a[3:0]);
            1: bus_wr(3'd1, d[3:0]);
            default: bus_wr(3'd2, d[7:4]);
         endcase
      end
      bus_wr(3'd3, ctl_word(1'b1, a));
   endtask

   task automatic wait_idle();
      logic [3:0] v;
      for (int k = 0; k < 4 * W; k++) begin
         peek(3'd3, v);
         if (!v[3]) break;
         @(negedge clk);
      end
   endtask

   task automatic read_byte(logic [5:0] a, bit fast, output logic [7:0] b);
      logic [3:0] lo, hi;
      fast_rd_i = fast;
      bus_wr(3'd0, a[3:0]);
      bus_wr(3'd3, ctl_word(1'b0, a));
      repeat (fast ? 3 : 1) @(negedge clk);
      peek(3'd1, lo);
      peek(3'd2, hi);
      b = {hi, lo};
   endtask

   // R3/R4 timing of one read in the chosen strobe mode
   task automatic timed_read(logic [5:0] a, bit fast, logic [7:0] exp);
      int n = fast ? 3 : 1;
      logic [3:0] v;
      fast_rd_i = fast;
      bus_wr(3'd1, 4'h0);
      bus_wr(3'd2, 4'h0);
      bus_wr(3'd0, a[3:0]);
      bus_wr(3'd3, ctl_word(1'b0, a));
      #1;
      chk("R4 strobe high after start", {7'd0, rd_strobe_o}, 8'd1);
      for (int k = 1; k <= n; k++) begin
         @(posedge clk); #1;
         chk("R4 strobe high early phase", {7'd0, rd_strobe_o}, 8'd1);
         @(negedge clk); #1;
         chk("R4 strobe late phase", {7'd0, rd_strobe_o}, (k < n) ? 8'd1 : 8'd0);
         peek(3'd1, v);
         chk("R3 low nibble timing", {4'd0, v}, (k < n) ? 8'd0 : {4'd0, exp[3:0]});
      end
      peek(3'd2, v);
      chk("R3 high nibble", {4'd0, v}, {4'd0, exp[7:4]});
   endtask

   initial begin
      #(4 * 150000);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [3:0] v;
      logic [7:0] b;
      void'($urandom(32'd1337));
      for (int i = 0; i < 64; i++) img_ok[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 4; s++) begin
         peek(3'(s), v);
         chk("R1 reset register", {4'd0, v}, 8'd0);
      end
      peek(3'd4, v);
      chk("R1 reset irq reg", {4'd0, v}, 8'h02);
      chk("R1 reset outputs", {6'd0, irq_o, rd_strobe_o}, 8'd0);

      // R5 exact busy length, R7 masked flag
      start_write(6'h2A, 8'h5C, 1'b0);
      peek(3'd3, v);
      chk("R5 busy set", {7'd0, v[3]}, 8'd1);
      repeat (W - 1) @(negedge clk);
      peek(3'd3, v);
      chk("R5 busy in last cycle", {7'd0, v[3]}, 8'd1);
      @(negedge clk);
      peek(3'd3, v);
      chk("R5 busy cleared", {7'd0, v[3]}, 8'd0);
      peek(3'd4, v);
      chk("R7 flag set, mask held", {4'd0, v}, 8'h03);
      chk("R7 irq masked", {7'd0, irq_o}, 8'd0);
      img[6'h2A] = 8'h5C; img_ok[6'h2A] = 1'b1;

      // R7 unmask, R8 clear
      bus_wr(3'd4, 4'b0000);
      chk("R7 irq unmasked", {7'd0, irq_o}, 8'd1);
      bus_wr(3'd4, 4'b0001);
      peek(3'd4, v);
      chk("R8 flag cleared", {4'd0, v}, 8'h00);
      chk("R8 irq low", {7'd0, irq_o}, 8'd0);

      // R3/R4 both strobe modes
      timed_read(6'h2A, 1'b0, 8'h5C);
      timed_read(6'h2A, 1'b1, 8'h5C);

      // R6 writes during busy ignored
      start_write(6'h05, 8'hA7, 1'b0);
      bus_wr(3'd0, 4'hF);
      bus_wr(3'd1, 4'h3);
      bus_wr(3'd3, 4'b0000);
      peek(3'd0, v);
      chk("R6 address kept", {4'd0, v}, 8'h05);
      peek(3'd1, v);
      chk("R6 data kept", {4'd0, v}, 8'h07);
      peek(3'd3, v);
      chk("R6 control kept", {4'd0, v}, 8'h0C);
      chk("R6 no read strobe", {7'd0, rd_strobe_o}, 8'd0);
      wait_idle();
      img[6'h05] = 8'hA7; img_ok[6'h05] = 1'b1;
      read_byte(6'h05, 1'b0, b);
      chk("R6 stored byte intact", b, 8'hA7);

      // R8 clear colliding with completion: flag must remain set
      bus_wr(3'd4, 4'b0001);
      start_write(6'h11, 8'h3E, 1'b0);
      repeat (W - 1) @(negedge clk);
      bus_we_i = 1'b1; bus_sel_i = 3'd4; bus_wdata_i = 4'b0001;
      @(negedge clk);
      bus_we_i = 1'b0;
      peek(3'd4, v);
      chk("R8 set wins over clear", {7'd0, v[0]}, 8'd1);
      img[6'h11] = 8'h3E; img_ok[6'h11] = 1'b1;
      bus_wr(3'd4, 4'b0001);

      // R2 four indexes differing in bits 4 and 5
      start_write(6'h0A, 8'h11, 1'b0); wait_idle();
      start_write(6'h1A, 8'h22, 1'b0); wait_idle();
      start_write(6'h3A, 8'h44, 1'b0); wait_idle();
      img[6'h0A] = 8'h11; img[6'h1A] = 8'h22; img[6'h3A] = 8'h44;
      img_ok[6'h0A] = 1; img_ok[6'h1A] = 1; img_ok[6'h3A] = 1;
      read_byte(6'h0A, 1'b0, b); chk("R2 index 0x0A", b, 8'h11);
      read_byte(6'h1A, 1'b1, b); chk("R2 index 0x1A", b, 8'h22);
      read_byte(6'h2A, 1'b0, b); chk("R2 index 0x2A", b, 8'h5C);
      read_byte(6'h3A, 1'b1, b); chk("R2 index 0x3A", b, 8'h44);
      bus_wr(3'd4, 4'b0001);

      // R9 sleep abort
      start_write(6'h0A, 8'h99, 1'b0);
      repeat (5) @(negedge clk);
      sleep_i = 1'b1;
      @(negedge clk);
      sleep_i = 1'b0;
      peek(3'd3, v);
      chk("R9 busy cleared by sleep", {7'd0, v[3]}, 8'd0);
      peek(3'd4, v);
      chk("R9 no flag on abort", {7'd0, v[0]}, 8'd0);
      read_byte(6'h0A, 1'b0, b);
      chk("R9 target erased", b, 8'hFF);
      img[6'h0A] = 8'hFF;

      // R10 reset abort
      start_write(6'h1A, 8'h66, 1'b0);
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      peek(3'd3, v);
      chk("R10 busy cleared by reset", {7'd0, v[3]}, 8'd0);
      read_byte(6'h1A, 1'b0, b);
      chk("R10 target erased", b, 8'hFF);
      img[6'h1A] = 8'hFF;
      read_byte(6'h3A, 1'b0, b);
      chk("R10 other byte kept", b, 8'h44);

      // random phase: R5 storage and R3 readback
      for (int i = 0; i < 16; i++) begin
         logic [5:0] a = 6'($urandom_range(0, 63));
         logic [7:0] d = 8'($urandom_range(0, 255));
         start_write(a, d, 1'b1);
         wait_idle();
         img[a] = d; img_ok[a] = 1'b1;
      end
      for (int i = 0; i < 24; i++) begin
         logic [5:0] a = 6'($urandom_range(0, 63));
         if (img_ok[a]) begin
            read_byte(a, bit'($urandom_range(0, 1)), b);
            chk("R5 random readback", b, img[a]);
         end
      end

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule